// File: doc/BRIEF.md
# Gate Driver Enable and Start-Up Sequencer

This block is the digital control for one channel of an isolated gate driver. It takes a synchronous PWM input and two supply flags: primary undervoltage and secondary undervoltage. It also reads back the level of a shared enable line. That line is wired-AND: every driver and the PWM controller can pull it low through an open-drain device. The block produces a pull-up request and a pull-down request for the output stage, plus a request to pull the shared enable line low.

The enable line does two jobs. While the primary supply is bad, or while the start delay is still counting, the block holds the line low itself. This lets the controller see when every driver on the line is ready. When the line reads low for any reason, the output is disabled. Once the line is released, the block waits for the secondary supply to report good. It then waits for a clean rising edge on the PWM input before it produces its first pulse. After that it follows the input, stretching short on-pulses and deferring a turn-on that comes too soon after a turn-off.

Top module: `gdrv_seq`

## Requirements
- R1: While reset is active, drv_hi is 0, drv_lo is 1 and en_pull_lo is 1.
- R2: In the cycle after pri_uv is sampled high, drv_hi is 0, drv_lo is 1 and en_pull_lo is 1, and they stay so while pri_uv stays high, whatever pwm_in does.
- R3: After pri_uv is first sampled low, en_pull_lo stays 1 for START_CYC further cycles and is 0 on the START_CYC+1-th rising edge. pwm_in has no effect on drv_hi during that time.
- R4: en_bus_in passes through a SYNC_STAGES-flop synchronizer (default 2). When the line falls, drv_hi is 0 from the third rising edge after the fall, and pwm_in is ignored while the line stays low.
- R5: After the enable line is seen high, drv_hi stays 0 while sec_uv is 1.
- R6: After enabling completes, the first pulse begins only at a rising edge of pwm_in. If pwm_in is already high, drv_hi stays 0 until pwm_in has been low for at least one cycle and then goes high again.
- R7: Each high period of drv_hi lasts at least MIN_ON_CYC cycles, even when pwm_in returns low sooner. The only exceptions are a supply fault and loss of enable.
- R8: Each low period of drv_hi between two pulses lasts at least MIN_OFF_CYC cycles. A turn-on request that comes earlier is deferred, not dropped.
- R9: drv_hi and drv_lo are never 1 in the same cycle. Outside of reset, exactly one of them is 1.
- R10: If sec_uv is sampled high while pulses are armed or running, drv_hi is 0 and en_pull_lo is 1 in the next cycle. The full START_CYC delay then runs again.
- R11: After a primary undervoltage during operation, the start delay restarts from zero. en_pull_lo falls exactly START_CYC+1 edges after pri_uv is first sampled low again.
- R12: While running with both width limits met, drv_hi follows pwm_in with one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_in | input | 1 | Synchronous PWM command |
| en_bus_in | input | 1 | Level read back from the shared wired-AND enable line |
| pri_uv | input | 1 | Primary supply undervoltage flag, 1 = bad |
| sec_uv | input | 1 | Secondary supply undervoltage flag, 1 = bad |
| drv_hi | output | 1 | Pull-up request for the gate output |
| drv_lo | output | 1 | Pull-down request for the gate output |
| en_pull_lo | output | 1 | Request to pull the shared enable line low |

## Verification
The latencies differ by path:
- A supply flag acts one edge after it is sampled.
- A fall of the enable line reaches drv_hi three edges later: two synchronizer flops plus the state register.
- The start delay ends START_CYC+1 edges after the primary flag clears.
- A pwm_in edge reaches drv_hi on the next edge, unless a width limit defers it.

Each expected value is queued with the exact cycle number at which it is due, counted from the falling edge where the stimulus was applied. It is compared on the falling edge of that cycle, so every register on the path is already counted. Values that must not change, such as no runt pulse or pwm ignored, are queued for every cycle of the window.

// File: rtl/gdrv_seq_pkg.sv
package gdrv_seq_pkg;

    typedef enum logic [2:0] {
        ST_UVLO  = 3'd0,  // primary supply bad
        ST_DELAY = 3'd1,  // start timer running
        ST_IDLE  = 3'd2,  // bus released, waiting for enable to read high
        ST_BIAS  = 3'd3,  // enabled, waiting for secondary supply good
        ST_ARM   = 3'd4,  // waiting for pwm low before the first edge
        ST_RUN   = 3'd5   // following pwm with width limits
    } seq_state_e;

    function automatic logic holds_bus(seq_state_e s);
        return (s == ST_UVLO) || (s == ST_DELAY);
    endfunction

endpackage

// File: rtl/gdrv_en_sync.sv
module gdrv_en_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sr_d, sr_q;

    always_comb begin
        sr_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            sr_d[i] = sr_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= sr_d;
    end

    assign dout = sr_q[STAGES-1];
endmodule

// File: rtl/gdrv_start_timer.sv
module gdrv_start_timer #(
    parameter int START_CYC = 25000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int TW = (START_CYC > 1) ? $clog2(START_CYC) : 1;
    localparam logic [TW-1:0] LAST = TW'(START_CYC - 1);

    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (!run)              cnt_d = '0;
        else if (cnt_q == LAST) cnt_d = cnt_q;
        else                   cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign done = run && (cnt_q == LAST);
endmodule

// File: rtl/gdrv_pulse_shaper.sv
module gdrv_pulse_shaper #(
    parameter int MIN_ON_CYC  = 3,
    parameter int MIN_OFF_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic allow,
    input  logic pwm,
    output logic pu_q,
    output logic pd_q
);
    localparam int ONW  = (MIN_ON_CYC > 1)  ? $clog2(MIN_ON_CYC)  : 1;
    localparam int OFFW = (MIN_OFF_CYC > 1) ? $clog2(MIN_OFF_CYC) : 1;
    localparam logic [ONW-1:0]  ON_LIM  = ONW'(MIN_ON_CYC - 1);
    localparam logic [OFFW-1:0] OFF_LIM = OFFW'(MIN_OFF_CYC - 1);

    typedef struct packed {
        logic            pu;
        logic            pd;
        logic [ONW-1:0]  on_cnt;
        logic [OFFW-1:0] off_cnt;
    } shp_t;

    shp_t s_d, s_q;
    logic on_ok, off_ok, hi_nxt;

    always_comb begin
        on_ok  = (s_q.on_cnt >= ON_LIM);
        off_ok = (s_q.off_cnt >= OFF_LIM);
        if (!allow)      hi_nxt = 1'b0;
        else if (s_q.pu) hi_nxt = pwm || !on_ok;
        else             hi_nxt = pwm && off_ok;

        s_d    = s_q;
        s_d.pu = hi_nxt;
        s_d.pd = !hi_nxt;
        if (s_q.pu) begin
            s_d.off_cnt = '0;
            s_d.on_cnt  = on_ok ? s_q.on_cnt : s_q.on_cnt + 1'b1;
        end else begin
            s_d.on_cnt  = '0;
            s_d.off_cnt = off_ok ? s_q.off_cnt : s_q.off_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.pu      <= 1'b0;
            s_q.pd      <= 1'b1;
            s_q.on_cnt  <= '0;
            s_q.off_cnt <= OFF_LIM;
        end else begin
            s_q <= s_d;
        end
    end

    assign pu_q = s_q.pu;
    assign pd_q = s_q.pd;
endmodule

// File: rtl/gdrv_seq.sv
module gdrv_seq #(
    parameter int START_CYC   = 25000,
    parameter int MIN_ON_CYC  = 3,
    parameter int MIN_OFF_CYC = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwm_in,
    input  logic en_bus_in,
    input  logic pri_uv,
    input  logic sec_uv,
    output logic drv_hi,
    output logic drv_lo,
    output logic en_pull_lo
);
    import gdrv_seq_pkg::*;

    typedef struct packed {
        seq_state_e state;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic en_sync, tmr_done, pull_q, en_seen, allow;

    gdrv_en_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (en_bus_in),
        .dout (en_sync)
    );

    gdrv_start_timer #(.START_CYC(START_CYC)) i_tmr (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (ctl_q.state == ST_DELAY),
        .done (tmr_done)
    );

    // own pull comes from a flop, so the readback never loops combinationally
    assign pull_q  = holds_bus(ctl_q.state);
    assign en_seen = en_sync && !pull_q;

    always_comb begin
        ctl_d = ctl_q;
        if (pri_uv) begin
            ctl_d.state = ST_UVLO;
        end else begin
            unique case (ctl_q.state)
                ST_UVLO:  ctl_d.state = ST_DELAY;
                ST_DELAY: if (tmr_done) ctl_d.state = ST_IDLE;
                ST_IDLE:  if (en_seen) ctl_d.state = ST_BIAS;
                ST_BIAS: begin
                    if (!en_seen)     ctl_d.state = ST_IDLE;
                    else if (!sec_uv) ctl_d.state = ST_ARM;
                end
                ST_ARM: begin
                    if (!en_seen)    ctl_d.state = ST_IDLE;
                    else if (sec_uv) ctl_d.state = ST_DELAY;
                    else if (!pwm_in) ctl_d.state = ST_RUN;
                end
                ST_RUN: begin
                    if (!en_seen)    ctl_d.state = ST_IDLE;
                    else if (sec_uv) ctl_d.state = ST_DELAY;
                end
                default: ctl_d.state = ST_UVLO;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q.state <= ST_UVLO;
        else        ctl_q <= ctl_d;
    end

    assign allow = (ctl_d.state == ST_RUN);

    gdrv_pulse_shaper #(
        .MIN_ON_CYC (MIN_ON_CYC),
        .MIN_OFF_CYC(MIN_OFF_CYC)
    ) i_shp (
        .clk  (clk),
        .rst_n(rst_n),
        .allow(allow),
        .pwm  (pwm_in),
        .pu_q (drv_hi),
        .pd_q (drv_lo)
    );

    assign en_pull_lo = pull_q;
endmodule

// File: rtl/gdrv_seq_chk.sv
module gdrv_seq_chk #(
    parameter int START_CYC   = 25000,
    parameter int MIN_ON_CYC  = 3,
    parameter int MIN_OFF_CYC = 8
) (
    input logic clk,
    input logic rst_n,
    input logic pri_uv,
    input logic sec_uv,
    input logic en_bus_in,
    input logic drv_hi,
    input logic drv_lo,
    input logic en_pull_lo
);
    localparam int SAT = START_CYC + MIN_ON_CYC + MIN_OFF_CYC + 2;

    int unsigned hi_len, lo_len, pl_len;
    logic [3:0]  en_low_hist;
    logic        abort_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_len      <= 0;
            lo_len      <= SAT;
            pl_len      <= SAT;
            en_low_hist <= '0;
            abort_q     <= 1'b0;
        end else begin
            hi_len      <= drv_hi ? ((hi_len < SAT) ? hi_len + 1 : hi_len) : 0;
            lo_len      <= drv_hi ? 0 : ((lo_len < SAT) ? lo_len + 1 : lo_len);
            pl_len      <= en_pull_lo ? ((pl_len < SAT) ? pl_len + 1 : pl_len) : 0;
            en_low_hist <= {en_low_hist[2:0], !en_bus_in};
            abort_q     <= pri_uv || sec_uv;
        end
    end

    AST_DRV_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(drv_hi && drv_lo) && (drv_hi || drv_lo)); // R9
    AST_PRI_HOLD: assert property (@(posedge clk) disable iff (!rst_n) pri_uv |=> (!drv_hi && en_pull_lo)); // R2
    AST_SEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n) sec_uv |=> !drv_hi); // R5
    AST_START_LEN: assert property (@(posedge clk) disable iff (!rst_n) $fell(en_pull_lo) |-> (pl_len >= START_CYC)); // R3
    AST_MIN_ON: assert property (@(posedge clk) disable iff (!rst_n) $fell(drv_hi) |-> (hi_len >= MIN_ON_CYC || abort_q || en_low_hist != 4'b0)); // R7
    AST_MIN_OFF: assert property (@(posedge clk) disable iff (!rst_n) $rose(drv_hi) |-> (lo_len >= MIN_OFF_CYC)); // R8
    AST_PULL_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n) en_pull_lo |-> !drv_hi); // R3
endmodule

bind gdrv_seq gdrv_seq_chk #(
    .START_CYC  (START_CYC),
    .MIN_ON_CYC (MIN_ON_CYC),
    .MIN_OFF_CYC(MIN_OFF_CYC)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pri_uv    (pri_uv),
    .sec_uv    (sec_uv),
    .en_bus_in (en_bus_in),
    .drv_hi    (drv_hi),
    .drv_lo    (drv_lo),
    .en_pull_lo(en_pull_lo)
);

// File: tb/test_gdrv_seq.sv
`timescale 1ns/1ps
module test_gdrv_seq;
    localparam int S    = 12;
    localparam int MON  = 3;
    localparam int MOFF = 5;

    logic clk = 1'b0;
    logic rst_n, pwm_in, pri_uv, sec_uv, ctrl_en;
    logic drv_hi, drv_lo, en_pull_lo, en_bus;
    int   cyc = 0;
    int   checks = 0;
    int   failures = 0;

    typedef struct {
        int    at;
        bit    chk_hi;
        logic  hi;
        bit    chk_pl;
        logic  pl;
        string tag;
    } exp_t;
    exp_t sb[$];

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    assign en_bus = ctrl_en & ~en_pull_lo;

    gdrv_seq #(.START_CYC(S), .MIN_ON_CYC(MON), .MIN_OFF_CYC(MOFF)) i_gdrv_seq (
        .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .en_bus_in(en_bus),
        .pri_uv(pri_uv), .sec_uv(sec_uv),
        .drv_hi(drv_hi), .drv_lo(drv_lo), .en_pull_lo(en_pull_lo)
    );

    task automatic exp_hi(int k, logic v, string tag);
        exp_t e;
        e.at = cyc + k; e.chk_hi = 1; e.hi = v; e.chk_pl = 0; e.pl = 1'b0; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic exp_pl(int k, logic v, string tag);
        exp_t e;
        e.at = cyc + k; e.chk_hi = 0; e.hi = 1'b0; e.chk_pl = 1; e.pl = v; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: compare every item due in this cycle
    always @(negedge clk) begin
        for (int i = sb.size() - 1; i >= 0; i--) begin
            if (sb[i].at == cyc) begin
                if (sb[i].chk_hi) begin
                    checks++;
                    if (drv_hi !== sb[i].hi || drv_lo !== !sb[i].hi) begin
                        failures++;
                        $display("FAIL %s cyc=%0d drv_hi/drv_lo actual=%b/%b expected=%b/%b",
                                 sb[i].tag, cyc, drv_hi, drv_lo, sb[i].hi, !sb[i].hi);
                    end
                end
                if (sb[i].chk_pl) begin
                    checks++;
                    if (en_pull_lo !== sb[i].pl) begin
                        failures++;
                        $display("FAIL %s cyc=%0d en_pull_lo actual=%b expected=%b",
                                 sb[i].tag, cyc, en_pull_lo, sb[i].pl);
                    end
                end
                sb.delete(i);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst_n = 1'b0; pri_uv = 1'b1; sec_uv = 1'b1; pwm_in = 1'b0; ctrl_en = 1'b1;
        @(negedge clk);
        exp_hi(1, 1'b0, "R1"); exp_pl(1, 1'b1, "R1");
        step(2);
        rst_n = 1'b1;
        pwm_in = 1'b1;                                   // R2: ignored under primary UV
        for (int k = 1; k <= 4; k++) begin exp_hi(k, 1'b0, "R2"); exp_pl(k, 1'b1, "R2"); end
        step(5);
        pwm_in = 1'b0;
        pri_uv = 1'b0;                                   // R3: start delay
        exp_pl(S, 1'b1, "R3"); exp_pl(S + 1, 1'b0, "R3");
        for (int k = 4; k <= 7; k++) exp_hi(k, 1'b0, "R3");
        step(3); pwm_in = 1'b1;
        step(3); pwm_in = 1'b0;
        step(S + 1 - 6);
        pwm_in = 1'b1;                                   // R5: secondary still bad
        for (int k = 1; k <= 10; k++) exp_hi(k, 1'b0, "R5");
        step(10);
        sec_uv = 1'b0;                                   // R6: pwm already high, no runt
        for (int k = 1; k <= 6; k++) exp_hi(k, 1'b0, "R6");
        step(6);
        pwm_in = 1'b0;
        step(2);
        pwm_in = 1'b1;
        exp_hi(1, 1'b1, "R6");
        step(1);
        pwm_in = 1'b0;                                   // R7: one-cycle input stretched
        exp_hi(1, 1'b1, "R7"); exp_hi(2, 1'b1, "R7"); exp_hi(3, 1'b0, "R7");
        step(3);
        pwm_in = 1'b1;                                   // R8: turn-on deferred
        exp_hi(1, 1'b0, "R8"); exp_hi(4, 1'b0, "R8"); exp_hi(5, 1'b1, "R8");
        exp_hi(15, 1'b1, "R12");
        step(16);
        pwm_in = 1'b0;
        exp_hi(1, 1'b0, "R12"); exp_hi(1, 1'b0, "R9");
        step(1);
        pwm_in = 1'b1;
        step(9);
        ctrl_en = 1'b0;                                  // R4: external disable
        exp_hi(2, 1'b1, "R4"); exp_hi(3, 1'b0, "R4"); exp_pl(3, 1'b0, "R4");
        step(4);
        for (int k = 1; k <= 6; k++) exp_hi(k, 1'b0, "R4");
        pwm_in = 1'b0; step(2); pwm_in = 1'b1; step(2); pwm_in = 1'b0; step(2);
        pwm_in = 1'b1; ctrl_en = 1'b1;                   // R6: re-enable with pwm high
        for (int k = 1; k <= 12; k++) exp_hi(k, 1'b0, "R6");
        step(12);
        pwm_in = 1'b0;
        step(2);
        pwm_in = 1'b1;
        exp_hi(1, 1'b1, "R6");
        step(6);
        sec_uv = 1'b1;                                   // R10: secondary fault while running
        exp_hi(1, 1'b0, "R10"); exp_pl(1, 1'b1, "R10");
        step(1);
        sec_uv = 1'b0;
        exp_pl(S - 1, 1'b1, "R10"); exp_pl(S, 1'b0, "R10");
        step(S);
        step(6); pwm_in = 1'b0;
        step(2); pwm_in = 1'b1;
        exp_hi(1, 1'b1, "R12");
        step(4);
        pri_uv = 1'b1;                                   // R2 and R11
        exp_hi(1, 1'b0, "R2"); exp_pl(1, 1'b1, "R2");
        for (int k = 2; k <= 4; k++) exp_pl(k, 1'b1, "R2");
        step(5);
        pri_uv = 1'b0;
        exp_pl(S, 1'b1, "R11"); exp_pl(S + 1, 1'b0, "R11");
        step(S + 4);
        if (sb.size() != 0) begin
            failures++;
            $display("FAIL scoreboard actual=%0d pending expected=0", sb.size());
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule